// File: doc/BRIEF.md
# Return Stack With Interrupt Entry

This block holds the return addresses of a small processor core in an on-chip last-in-first-out store. It also runs the entry into and exit from the single external interrupt. At each instruction boundary the core reports whether the finishing instruction is a subroutine call, a plain return or a return-from-interrupt. The block pushes or pops the store to match, and it supplies the next program counter one cycle later.

An external interrupt enters as a forced subroutine call into page zero. The interrupting device provides a signed 7-bit offset, and the handler address is that offset taken from byte 0 of page zero. Taking the interrupt sets the Interrupt Inhibit bit. The two return flavours differ in one way only: one clears Interrupt Inhibit and the other leaves it as it is. Software can also set or clear the bit through a write port.

Top module: `retstk_irq_ctrl`

## Requirements
- R1: A call (call_req with insn_done) pushes next_pc_in and, on the next cycle, shows pc_load=1, stk_push=1 and pc_next=call_target.
- R2: A plain return (ret_req with insn_done) pops the store and, on the next cycle, shows pc_load=1, stk_pop=1 and pc_next equal to the most recently pushed address that is still in the store. inhibit is unchanged.
- R3: A return-from-interrupt (reti_req with insn_done) pops the store in the same way as R2 and clears inhibit on the next cycle.
- R4: An interrupt is taken only in a cycle with insn_done=1, irq_req=1 and inhibit=0 in which none of call_req, ret_req or reti_req is high. irq_ack is high in that same cycle, and it is in that cycle that irq_vec is sampled. A request that coincides with a call or return waits for a later boundary.
- R5: Taking an interrupt pushes next_pc_in. On the next cycle it shows inhibit=1, stk_push=1, pc_load=1 and pc_next = {2'b00, six copies of irq_vec[6], irq_vec[6:0]}, which lies in 0000h-003Fh or 1FC0h-1FFFh. irq_vec[7] is ignored.
- R6: While inhibit=1, irq_req is ignored: irq_ack stays 0 and no push or program counter load follows.
- R7: The store has 8 entries of 15 bits and a wrapping 3-bit pointer. A ninth push overwrites the oldest entry, and pops keep wrapping past empty.
- R8: inh_wr_en=1 loads inh_wr_val into inhibit on the next edge. If an interrupt is taken in the same cycle, inhibit ends up 1.
- R9: After reset, inhibit=0, pc_load=0, stk_push=0, stk_pop=0, pc_next=0, and the store is empty with its pointer at 0.
- R10: Requests without insn_done have no effect. When several requests are high together, call has priority over plain return, and plain return has priority over return-from-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_done | input | 1 | Instruction boundary strobe |
| call_req | input | 1 | Finishing instruction is a subroutine call |
| call_target | input | 15 | Call destination address |
| ret_req | input | 1 | Plain return, inhibit kept |
| reti_req | input | 1 | Return that clears inhibit |
| next_pc_in | input | 15 | Address of the next instruction |
| irq_req | input | 1 | External interrupt request (level) |
| irq_vec | input | 8 | Device-supplied offset byte |
| inh_wr_en | input | 1 | Software write strobe for inhibit |
| inh_wr_val | input | 1 | Value written to inhibit |
| irq_ack | output | 1 | Interrupt taken this cycle |
| inhibit | output | 1 | Interrupt Inhibit bit |
| pc_load | output | 1 | pc_next is valid |
| pc_next | output | 15 | Next program counter |
| stk_push | output | 1 | A push happened on the last edge |
| stk_pop | output | 1 | A pop happened on the last edge |

## Verification
Nested calls followed by a mix of both return flavours show whether ordering is kept and whether only the interrupt return touches inhibit. The interrupt vectors used are 05h with bit 7 set, 3Fh, 40h and 7Fh. Together they separate correct sign extension from zero extension at both ends of each window of page zero. An interrupt is raised in cycles that carry a call, in cycles without a boundary, while inhibit is set, and together with a software clear. Each case tells apart a design that gates the request correctly from one that takes it too early or lets the software write win. Nine pushes followed by nine pops expose whether the pointer wraps and which entry gets overwritten.

// File: rtl/retstk_pkg.sv
// Package: shared widths, request encoding and the page-zero target helper.
// Assumes a 15-bit address space with 13-bit pages and 7-bit signed offsets.
package retstk_pkg;
    localparam int ADDR_W = 15;
    localparam int PAGE_W = 13;
    localparam int OFS_W  = 7;
    localparam int VEC_W  = 8;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_CALL = 2'd1,
        OP_RET  = 2'd2,
        OP_RETI = 2'd3
    } stk_op_e;

    // Signed offset from byte 0 of page zero, folded into that page.
    function automatic logic [ADDR_W-1:0] zero_page_target(input logic [VEC_W-1:0] vec);
        return {{(ADDR_W-PAGE_W){1'b0}},
                {(PAGE_W-OFS_W){vec[OFS_W-1]}},
                vec[OFS_W-1:0]};
    endfunction
endpackage

// File: rtl/retstk_lifo.sv
// Module: return-address LIFO with a wrapping pointer.
// Assumes push and pop never arrive together; overflow overwrites the
// oldest entry and underflow keeps wrapping.
module retstk_lifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] top
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] sp;
    logic [PTR_W-1:0] sp_inc;
    logic [PTR_W-1:0] sp_dec;
    logic [WIDTH-1:0] entry [DEPTH];

    // Pointer neighbours with explicit wrap for any depth.
    always_comb begin
        sp_inc = (sp == LAST) ? '0 : sp + 1'b1;
        sp_dec = (sp == '0) ? LAST : sp - 1'b1;
    end

    // Pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= '0;
        else if (push) sp <= sp_inc;
        else if (pop)  sp <= sp_dec;
    end

    // One storage register per entry, written at the pointer on a push.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)                          entry[g] <= '0;
            else if (push && sp == PTR_W'(g))    entry[g] <= din;
        end
    end

    // Most recent entry, the one a pop returns.
    assign top = entry[sp_dec];
endmodule

// File: rtl/retstk_irq_arb.sv
// Module: interrupt acceptance and the Interrupt Inhibit bit.
// Assumes insn_done marks an instruction boundary and no_cmd means the
// finishing instruction carried no call or return.
module retstk_irq_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic insn_done,
    input  logic no_cmd,
    input  logic irq_req,
    input  logic reti_acc,
    input  logic inh_wr_en,
    input  logic inh_wr_val,
    output logic take,
    output logic inhibit
);
    // An interrupt is accepted only at a free boundary while not inhibited.
    assign take = insn_done & no_cmd & irq_req & ~inhibit;

    // Inhibit update; the later assignment wins: write, then return clear, then interrupt set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inhibit <= 1'b0;
        end else begin
            if (inh_wr_en) inhibit <= inh_wr_val;
            if (reti_acc)  inhibit <= 1'b0;
            if (take)      inhibit <= 1'b1;
        end
    end
endmodule

// File: rtl/retstk_pc_sel.sv
// Module: registers the next program counter and the push/pop pulses.
// Assumes at most one of op and take is active per cycle.
module retstk_pc_sel
    import retstk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_e           op,
    input  logic              take,
    input  logic [ADDR_W-1:0] call_target,
    input  logic [ADDR_W-1:0] stack_top,
    input  logic [VEC_W-1:0]  irq_vec,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_next,
    output logic              stk_push,
    output logic              stk_pop
);
    logic [ADDR_W-1:0] target_d;

    // Picks the destination for this boundary.
    always_comb begin
        unique case (op)
            OP_CALL:         target_d = call_target;
            OP_RET, OP_RETI: target_d = stack_top;
            default:         target_d = zero_page_target(irq_vec);
        endcase
    end

    // Registers the outcome of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_load  <= 1'b0;
            pc_next  <= '0;
            stk_push <= 1'b0;
            stk_pop  <= 1'b0;
        end else begin
            pc_load  <= (op != OP_NONE) | take;
            stk_push <= (op == OP_CALL) | take;
            stk_pop  <= (op == OP_RET) | (op == OP_RETI);
            if ((op != OP_NONE) | take) pc_next <= target_d;
        end
    end
endmodule

// File: rtl/retstk_irq_ctrl.sv
// Module: top of the return stack with interrupt entry and exit.
// Assumes requests are qualified by insn_done; call beats return beats
// return-from-interrupt.
module retstk_irq_ctrl
    import retstk_pkg::*;
#(
    parameter int STACK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  logic              call_req,
    input  logic [14:0]       call_target,
    input  logic              ret_req,
    input  logic              reti_req,
    input  logic [14:0]       next_pc_in,
    input  logic              irq_req,
    input  logic [7:0]        irq_vec,
    input  logic              inh_wr_en,
    input  logic              inh_wr_val,
    output logic              irq_ack,
    output logic              inhibit,
    output logic              pc_load,
    output logic [14:0]       pc_next,
    output logic              stk_push,
    output logic              stk_pop
);
    stk_op_e           op;
    logic              take;
    logic [ADDR_W-1:0] stack_top;

    // Priority decode of the finishing instruction's request.
    always_comb begin
        if (!insn_done)    op = OP_NONE;
        else if (call_req) op = OP_CALL;
        else if (ret_req)  op = OP_RET;
        else if (reti_req) op = OP_RETI;
        else               op = OP_NONE;
    end

    retstk_irq_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_done  (insn_done),
        .no_cmd     (op == OP_NONE),
        .irq_req    (irq_req),
        .reti_acc   (op == OP_RETI),
        .inh_wr_en  (inh_wr_en),
        .inh_wr_val (inh_wr_val),
        .take       (take),
        .inhibit    (inhibit)
    );

    retstk_lifo #(.DEPTH(STACK_DEPTH), .WIDTH(ADDR_W)) u_lifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  ((op == OP_CALL) | take),
        .pop   ((op == OP_RET) | (op == OP_RETI)),
        .din   (next_pc_in),
        .top   (stack_top)
    );

    retstk_pc_sel u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .take        (take),
        .call_target (call_target),
        .stack_top   (stack_top),
        .irq_vec     (irq_vec),
        .pc_load     (pc_load),
        .pc_next     (pc_next),
        .stk_push    (stk_push),
        .stk_pop     (stk_pop)
    );

    assign irq_ack = take;
endmodule

// File: rtl/retstk_irq_ctrl_chk.sv
// Module: protocol checker bound to the top module.
module retstk_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_done,
    input logic        call_req,
    input logic        ret_req,
    input logic        reti_req,
    input logic        inh_wr_en,
    input logic        irq_ack,
    input logic        inhibit,
    input logic        pc_load,
    input logic [14:0] pc_next,
    input logic        stk_push,
    input logic        stk_pop
);
    // R4
    ack_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> insn_done && !call_req && !ret_req && !reti_req);
    // R6
    ack_not_inhibited_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !inhibit);
    // R5
    ack_sets_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> inhibit && stk_push && pc_load && pc_next[14:13] == 2'b00);
    // R3
    reti_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done && reti_req && !call_req && !ret_req |=> !inhibit && stk_pop);
    // R2
    ret_keeps_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done && ret_req && !call_req && !inh_wr_en |=> inhibit == $past(inhibit) && stk_pop);
    // R10
    one_stack_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stk_push, stk_pop}));
    // R10
    idle_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_done |=> !pc_load);
endmodule

bind retstk_irq_ctrl retstk_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_done (insn_done),
    .call_req  (call_req),
    .ret_req   (ret_req),
    .reti_req  (reti_req),
    .inh_wr_en (inh_wr_en),
    .irq_ack   (irq_ack),
    .inhibit   (inhibit),
    .pc_load   (pc_load),
    .pc_next   (pc_next),
    .stk_push  (stk_push),
    .stk_pop   (stk_pop)
);

// File: tb/retstk_irq_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module retstk_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        insn_done, call_req, ret_req, reti_req, irq_req, inh_wr_en, inh_wr_val;
    logic [14:0] call_target, next_pc_in;
    logic [7:0]  irq_vec;
    logic        irq_ack, inhibit, pc_load, stk_push, stk_pop;
    logic [14:0] pc_next;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    retstk_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .call_req(call_req),
        .call_target(call_target), .ret_req(ret_req), .reti_req(reti_req),
        .next_pc_in(next_pc_in), .irq_req(irq_req), .irq_vec(irq_vec),
        .inh_wr_en(inh_wr_en), .inh_wr_val(inh_wr_val), .irq_ack(irq_ack),
        .inhibit(inhibit), .pc_load(pc_load), .pc_next(pc_next),
        .stk_push(stk_push), .stk_pop(stk_pop)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        insn_done = 0; call_req = 0; ret_req = 0; reti_req = 0; irq_req = 0;
        inh_wr_en = 0; inh_wr_val = 0; call_target = '0; next_pc_in = '0; irq_vec = '0;
    endtask

    // Advance through one edge and settle; inputs are then cleared at the negedge.
    task automatic edge_step();
        @(posedge clk); #1;
    endtask

    task automatic to_negedge();
        @(negedge clk); idle_inputs();
    endtask

    task automatic do_reset();
        @(negedge clk); idle_inputs(); rst_n = 0;
        edge_step(); edge_step();
        @(negedge clk); rst_n = 1;
    endtask

    task automatic do_call(input logic [14:0] tgt, input logic [14:0] npc);
        insn_done = 1; call_req = 1; call_target = tgt; next_pc_in = npc;
        edge_step(); to_negedge();
    endtask

    task automatic do_ret(input bit clear, input logic [14:0] exp, input string req);
        insn_done = 1; ret_req = !clear; reti_req = clear;
        edge_step();
        chk(req, {pc_load, stk_pop, stk_push}, 3'b110);
        chk(req, pc_next, exp);
        to_negedge();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R9 reset", {inhibit, pc_load, stk_push, stk_pop}, 4'b0);
        chk("R9 reset pc", pc_next, 0);
    endtask

    task automatic t_call_ret();
        do_reset();
        insn_done = 1; call_req = 1; call_target = 15'h1234; next_pc_in = 15'h0102;
        edge_step();
        chk("R1 call", {pc_load, stk_push, stk_pop}, 3'b110);
        chk("R1 call target", pc_next, 15'h1234);
        to_negedge();
        do_call(15'h2000, 15'h1237);
        inh_wr_en = 1; inh_wr_val = 1; edge_step(); to_negedge();
        do_ret(0, 15'h1237, "R2 ret inner");
        chk("R2 inhibit kept", inhibit, 1);
        do_ret(1, 15'h0102, "R3 reti outer");
        chk("R3 inhibit cleared", inhibit, 0);
    endtask

    task automatic t_irq(input logic [7:0] vec, input logic [14:0] exp, input string req);
        do_reset();
        insn_done = 1; irq_req = 1; irq_vec = vec; next_pc_in = 15'h4321; #1;
        chk(req, irq_ack, 1);
        edge_step();
        chk(req, {inhibit, stk_push, pc_load}, 3'b111);
        chk(req, pc_next, exp);
        to_negedge();
        do_ret(1, 15'h4321, "R3 irq return");
        chk("R3 irq return inhibit", inhibit, 0);
    endtask

    task automatic t_irq_gating();
        do_reset();
        // Request without a boundary.
        irq_req = 1; #1; chk("R4 no boundary", irq_ack, 0);
        edge_step(); chk("R4 no boundary load", pc_load, 0); to_negedge();
        // Request at a boundary that carries a call.
        insn_done = 1; irq_req = 1; call_req = 1; call_target = 15'h0500; next_pc_in = 15'h0010; #1;
        chk("R4 waits for call", irq_ack, 0);
        edge_step(); chk("R4 call wins", pc_next, 15'h0500); chk("R4 inhibit", inhibit, 0);
        to_negedge();
        // Inhibited request.
        inh_wr_en = 1; inh_wr_val = 1; edge_step(); to_negedge();
        insn_done = 1; irq_req = 1; irq_vec = 8'h05; #1;
        chk("R6 ignored ack", irq_ack, 0);
        edge_step(); chk("R6 ignored load", {pc_load, stk_push}, 2'b00); to_negedge();
        // Software clear together with a taken interrupt.
        inh_wr_en = 1; inh_wr_val = 0; edge_step(); to_negedge();
        chk("R8 sw clear", inhibit, 0);
        insn_done = 1; irq_req = 1; irq_vec = 8'h05; inh_wr_en = 1; inh_wr_val = 0; #1;
        chk("R8 ack", irq_ack, 1);
        edge_step(); chk("R8 irq set wins", inhibit, 1); to_negedge();
    endtask

    task automatic t_wrap();
        do_reset();
        for (int i = 0; i < 9; i++) do_call(15'h0700, 15'(15'h0100 + i));
        for (int i = 8; i >= 1; i--) do_ret(0, 15'(15'h0100 + i), "R7 wrap pop");
        do_ret(0, 15'h0108, "R7 underflow wrap");
    endtask

    task automatic t_priority();
        do_reset();
        do_call(15'h0001, 15'h0AAA);
        do_call(15'h0002, 15'h0BBB);
        // Call without a boundary must not push.
        call_req = 1; call_target = 15'h7777; next_pc_in = 15'h0CCC;
        edge_step(); chk("R10 no boundary", pc_load, 0); to_negedge();
        // ret and reti together: plain return wins, inhibit untouched.
        inh_wr_en = 1; inh_wr_val = 1; edge_step(); to_negedge();
        insn_done = 1; ret_req = 1; reti_req = 1;
        edge_step(); chk("R10 ret beats reti", pc_next, 15'h0BBB); chk("R10 inhibit", inhibit, 1);
        to_negedge();
        insn_done = 1; call_req = 1; ret_req = 1; call_target = 15'h0333; next_pc_in = 15'h0DDD;
        edge_step(); chk("R10 call beats ret", {stk_push, stk_pop}, 2'b10);
        chk("R10 call target", pc_next, 15'h0333); to_negedge();
        do_ret(0, 15'h0DDD, "R10 pushed by call");
        do_ret(0, 15'h0AAA, "R10 stack intact");
    endtask

    initial begin
        idle_inputs(); rst_n = 0;
        t_reset();
        t_call_ret();
        t_irq(8'h85, 15'h0005, "R5 vec 85h");
        t_irq(8'h3F, 15'h003F, "R5 vec 3Fh");
        t_irq(8'h40, 15'h1FC0, "R5 vec 40h");
        t_irq(8'h7F, 15'h1FFF, "R5 vec 7Fh");
        t_irq_gating();
        t_wrap();
        t_priority();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule